// File: doc/BRIEF.md
# Dual Cascadable Down-Counter Timer

This block holds two programmable down-counters, channel 0 and channel 1, each W bits wide (8 by default). Each channel has a reload register, a run control, and a choice between continuous auto-reload and single-shot operation. When a running channel reaches zero on a count-enable cycle, it reports an underflow pulse in that same cycle and reloads. A cascade setting joins the two into one 2W-bit counter. In that setting, channel 0 is the low half, channel 1 steps only when channel 0 wraps, and channel 0's run control governs the pair.

A square-wave output flips its phase on every underflow from a chosen source. It is gated by an enable. When disabled, the true output sits high and the complementary output sits low. Software reaches the block through a simple write port and a combinational read port. The count rate comes from the `cnt_en` strobe.

Each channel is built around a two-state machine. CH_STOP moves to CH_RUN on START, a control write with the run bit set. CH_RUN moves back to CH_STOP on HALT (a control write with the run bit clear), on EXPIRE (a single-shot underflow), or on FORCE (cascade forcing channel 1 off). The wave generator has two states, TW_LOW and TW_HIGH, and crosses between them on TOGGLE, which is a selected underflow.

Top module: `dual_dtimer`

## Requirements
- R1: After reset, every control bit, both reload registers and both counts read 0. `tout` is 1 and `tout_n` is 0.
- R2: Writing address 0 sets the run bits from data bit 0 (channel 0) and bit 1 (channel 1): 1 starts the channel, 0 stops it. The run bits read back at the same positions.
- R3: On each cycle with `cnt_en` high and a channel running, the count drops by one. If the count is 0 instead, that channel's underflow output pulses in the same cycle and the count reloads from its reload register. Auto-reload therefore gives one underflow every reload+1 enabled cycles.
- R4: A stopped channel, or a cycle with `cnt_en` low, leaves the count unchanged. A restarted channel continues from the held value.
- R5: With single-shot selected (address 0, bit 2 for channel 0, bit 3 for channel 1), an underflow clears that channel's run bit. A control write in the same cycle takes priority over this clear.
- R6: Writing address 3 with data bit n set loads channel n's count from its reload register at the next edge, whether the channel is running or stopped. That cycle produces no decrement and no underflow on that channel.
- R7: With cascade set (address 0, bit 4), channel 1 steps only on a channel 0 wrap. `ufl1` pulses only when both halves are 0 on an enabled cycle. Channel 1's run bit is forced to 0.
- R8: In cascade, channel 0's single-shot bit applies to the pair. The run bit clears only on the combined underflow.
- R9: The source-select bit (address 0, bit 5) picks channel 0 underflows when 1 and channel 1 underflows when 0. In cascade the combined underflow is used and the bit is ignored.
- R10: The wave phase starts low and flips at each edge that follows a selected underflow.
- R11: With the output enable (address 0, bit 6) at 0, `tout` is 1 and `tout_n` is 0. With it at 1, `tout` follows the phase and `tout_n` is its complement.
- R12: The read map is: address 0 control image, 1 and 2 reload 0/1, 3 and 4 count 0/1. Addresses 5 to 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | W | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | W | Read data (combinational) |
| cnt_en | input | 1 | Count-enable strobe |
| ufl0 | output | 1 | Channel 0 underflow pulse |
| ufl1 | output | 1 | Channel 1 (or combined) underflow pulse |
| tout | output | 1 | Square-wave output |
| tout_n | output | 1 | Complementary square-wave output |

## Verification
The assertions check, on every cycle, the following:
- the output gating levels and the complement relation of the wave pins;
- channel 1's run bit staying low in cascade;
- a combined underflow coinciding with a low-half wrap;
- the reload after an underflow;
- the count holding while nothing touches it;
- the single-shot stop.

Only the bench's scenarios can show several other behaviours:
- the exact underflow spacing for a given reload;
- resume from a held count;
- preset priority over counting;
- which source drives the wave under each select and cascade setting;
- the read map.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;

    localparam int unsigned ADDR_W = 3;

    // write and read addresses
    localparam int unsigned A_CTRL   = 0;
    localparam int unsigned A_RLD0   = 1;
    localparam int unsigned A_PRESET = 3;
    localparam int unsigned A_CNT0   = 3;
    localparam int unsigned A_CNT1   = 4;

    // control byte bit positions
    localparam int unsigned B_RUN0 = 0;
    localparam int unsigned B_RUN1 = 1;
    localparam int unsigned B_OS0  = 2;
    localparam int unsigned B_OS1  = 3;
    localparam int unsigned B_CASC = 4;
    localparam int unsigned B_SEL  = 5;
    localparam int unsigned B_TEN  = 6;

    typedef enum logic {
        CH_STOP = 1'b0,
        CH_RUN  = 1'b1
    } ch_state_t;

    typedef enum logic {
        TW_LOW  = 1'b0,
        TW_HIGH = 1'b1
    } tw_state_t;

    typedef struct packed {
        logic oneshot0;
        logic oneshot1;
        logic cascade;
        logic chsel;
        logic tout_en;
    } cfg_t;

endpackage

// File: rtl/dtmr_chan.sv
module dtmr_chan
    import dtmr_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         chained,
    input  logic         start_req,
    input  logic         halt_req,
    input  logic         force_stop,
    input  logic         stop_evt,
    input  logic         preset,
    input  logic [W-1:0] reload,
    output logic [W-1:0] count,
    output logic         running,
    output logic         wrap
);

    ch_state_t state_q;
    ch_state_t state_d;
    logic      adv;
    logic      at_floor;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CH_STOP;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: START, HALT, EXPIRE, FORCE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_STOP: begin
                if (start_req && !force_stop) begin
                    state_d = CH_RUN;
                end
            end
            CH_RUN: begin
                if (force_stop || halt_req) begin
                    state_d = CH_STOP;
                end else if (start_req) begin
                    state_d = CH_RUN;
                end else if (stop_evt) begin
                    state_d = CH_STOP;
                end
            end
            default: state_d = CH_STOP;
        endcase
    end

    // outputs
    always_comb begin
        running = (state_q == CH_RUN);
    end

    always_comb begin
        adv      = tick && (running || chained) && !preset;
        at_floor = (count == '0);
        wrap     = adv && at_floor;
    end

    // count register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (preset || wrap) begin
            count <= reload;
        end else if (adv) begin
            count <= count - 1'b1;
        end
    end

endmodule

// File: rtl/dtmr_regs.sv
module dtmr_regs
    import dtmr_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [W-1:0]      wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              run0,
    input  logic              run1,
    input  logic [W-1:0]      cnt0,
    input  logic [W-1:0]      cnt1,
    output cfg_t              cfg,
    output logic [W-1:0]      rld0,
    output logic [W-1:0]      rld1,
    output logic [1:0]        start_req,
    output logic [1:0]        halt_req,
    output logic [1:0]        preset,
    output logic              force1,
    output logic [W-1:0]      rd_data
);

    localparam int unsigned NCH = 2;

    logic       ctrl_wr;
    logic       pre_wr;
    logic [7:0] ctrl_img;
    logic [W-1:0] rld_q [NCH];

    always_comb begin
        ctrl_wr = wr_en && (wr_addr == ADDR_W'(A_CTRL));
        pre_wr  = wr_en && (wr_addr == ADDR_W'(A_PRESET));
    end

    // reload registers, one per channel
    for (genvar i = 0; i < NCH; i++) begin : g_rld
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rld_q[i] <= '0;
            end else if (wr_en && (wr_addr == ADDR_W'(A_RLD0 + i))) begin
                rld_q[i] <= wr_data;
            end
        end

        always_comb begin
            start_req[i] = ctrl_wr && wr_data[i];
            halt_req[i]  = ctrl_wr && !wr_data[i];
            preset[i]    = pre_wr && wr_data[i];
        end
    end

    always_comb begin
        rld0 = rld_q[0];
        rld1 = rld_q[1];
    end

    // mode and output configuration
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (ctrl_wr) begin
            cfg.oneshot0 <= wr_data[B_OS0];
            cfg.oneshot1 <= wr_data[B_OS1];
            cfg.cascade  <= wr_data[B_CASC];
            cfg.chsel    <= wr_data[B_SEL];
            cfg.tout_en  <= wr_data[B_TEN];
        end
    end

    // cascade forces channel 1 off, including the write that sets it
    always_comb begin
        force1 = cfg.cascade || (ctrl_wr && wr_data[B_CASC]);
    end

    always_comb begin
        ctrl_img          = '0;
        ctrl_img[B_RUN0]  = run0;
        ctrl_img[B_RUN1]  = run1;
        ctrl_img[B_OS0]   = cfg.oneshot0;
        ctrl_img[B_OS1]   = cfg.oneshot1;
        ctrl_img[B_CASC]  = cfg.cascade;
        ctrl_img[B_SEL]   = cfg.chsel;
        ctrl_img[B_TEN]   = cfg.tout_en;
    end

    always_comb begin
        case (rd_addr)
            ADDR_W'(A_CTRL):     rd_data = W'(ctrl_img);
            ADDR_W'(A_RLD0):     rd_data = rld_q[0];
            ADDR_W'(A_RLD0 + 1): rd_data = rld_q[1];
            ADDR_W'(A_CNT0):     rd_data = cnt0;
            ADDR_W'(A_CNT1):     rd_data = cnt1;
            default:             rd_data = '0;
        endcase
    end

endmodule

// File: rtl/dtmr_tout.sv
module dtmr_tout
    import dtmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic toggle,
    input  logic enable,
    output logic tout,
    output logic tout_n
);

    tw_state_t st_q;
    tw_state_t st_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= TW_LOW;
        end else begin
            st_q <= st_d;
        end
    end

    // TOGGLE transition in both directions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            TW_LOW:  if (toggle) st_d = TW_HIGH;
            TW_HIGH: if (toggle) st_d = TW_LOW;
            default: st_d = TW_LOW;
        endcase
    end

    always_comb begin
        if (enable) begin
            tout   = (st_q == TW_HIGH);
            tout_n = (st_q == TW_LOW);
        end else begin
            tout   = 1'b1;
            tout_n = 1'b0;
        end
    end

endmodule

// File: rtl/dual_dtimer.sv
module dual_dtimer
    import dtmr_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [W-1:0]      wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [W-1:0]      rd_data,
    input  logic              cnt_en,
    output logic              ufl0,
    output logic              ufl1,
    output logic              tout,
    output logic              tout_n
);

    cfg_t         cfg;
    logic [W-1:0] rld0;
    logic [W-1:0] rld1;
    logic [W-1:0] cnt0;
    logic [W-1:0] cnt1;
    logic [1:0]   start_req;
    logic [1:0]   halt_req;
    logic [1:0]   preset;
    logic         force1;
    logic         run0;
    logic         run1;
    logic         wrap0;
    logic         wrap1;
    logic         tick1;
    logic         stop0;
    logic         stop1;
    logic         sel_ufl;
    logic         casc;
    logic         os0;
    logic         ten;

    always_comb begin
        casc = cfg.cascade;
        os0  = cfg.oneshot0;
        ten  = cfg.tout_en;
    end

    dtmr_regs #(.W(W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .run0      (run0),
        .run1      (run1),
        .cnt0      (cnt0),
        .cnt1      (cnt1),
        .cfg       (cfg),
        .rld0      (rld0),
        .rld1      (rld1),
        .start_req (start_req),
        .halt_req  (halt_req),
        .preset    (preset),
        .force1    (force1),
        .rd_data   (rd_data)
    );

    always_comb begin
        tick1 = casc ? wrap0 : cnt_en;
        stop0 = cfg.oneshot0 && (casc ? wrap1 : wrap0);
        stop1 = cfg.oneshot1 && wrap1;
    end

    dtmr_chan #(.W(W)) u_ch0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (cnt_en),
        .chained    (1'b0),
        .start_req  (start_req[0]),
        .halt_req   (halt_req[0]),
        .force_stop (1'b0),
        .stop_evt   (stop0),
        .preset     (preset[0]),
        .reload     (rld0),
        .count      (cnt0),
        .running    (run0),
        .wrap       (wrap0)
    );

    dtmr_chan #(.W(W)) u_ch1 (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick1),
        .chained    (casc),
        .start_req  (start_req[1]),
        .halt_req   (halt_req[1]),
        .force_stop (force1),
        .stop_evt   (stop1),
        .preset     (preset[1]),
        .reload     (rld1),
        .count      (cnt1),
        .running    (run1),
        .wrap       (wrap1)
    );

    always_comb begin
        ufl0    = wrap0;
        ufl1    = wrap1;
        sel_ufl = casc ? wrap1 : (cfg.chsel ? wrap0 : wrap1);
    end

    dtmr_tout u_tout (
        .clk    (clk),
        .rst_n  (rst_n),
        .toggle (sel_ufl),
        .enable (cfg.tout_en),
        .tout   (tout),
        .tout_n (tout_n)
    );

endmodule

// File: rtl/dtmr_checker.sv
module dtmr_checker #(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cnt_en,
    input logic         wr_en,
    input logic [2:0]   wr_addr,
    input logic         ufl0,
    input logic         ufl1,
    input logic         tout,
    input logic         tout_n,
    input logic         run0,
    input logic         run1,
    input logic         casc,
    input logic         os0,
    input logic         ten,
    input logic [W-1:0] cnt0,
    input logic [W-1:0] rld0
);

    AST_TOUT_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        !ten |-> (tout && !tout_n)); // R11

    AST_TOUT_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n)
        ten |-> (tout != tout_n)); // R11

    AST_CASC_RUN1_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        casc |-> !run1); // R7

    AST_CASC_UFL_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (casc && ufl1) |-> ufl0); // R7

    AST_UFL_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
        ufl0 |=> (cnt0 == $past(rld0))); // R3

    AST_COUNT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && !wr_en) |=> $stable(cnt0)); // R4

    AST_ONESHOT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (os0 && !casc && ufl0 && !(wr_en && wr_addr == 3'd0)) |=> !run0); // R5

endmodule

bind dual_dtimer dtmr_checker #(.W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cnt_en  (cnt_en),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .ufl0    (ufl0),
    .ufl1    (ufl1),
    .tout    (tout),
    .tout_n  (tout_n),
    .run0    (run0),
    .run1    (run1),
    .casc    (casc),
    .os0     (os0),
    .ten     (ten),
    .cnt0    (cnt0),
    .rld0    (rld0)
);

// File: tb/dual_dtimer_bench.sv
`timescale 1ns/1ps
module dual_dtimer_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       cnt_en = 1'b0;
    logic       ufl0;
    logic       ufl1;
    logic       tout;
    logic       tout_n;

    int n_chk  = 0;
    int n_fail = 0;

    // behavioural model state
    logic m_run0 = 0, m_run1 = 0, m_os0 = 0, m_os1 = 0;
    logic m_casc = 0, m_sel = 0, m_ten = 0, m_ph = 0;
    logic [7:0] m_rl0 = 0, m_rl1 = 0, m_c0 = 0, m_c1 = 0;

    always #2.5 clk = ~clk;

    dual_dtimer u_dual_dtimer (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .cnt_en  (cnt_en),
        .ufl0    (ufl0),
        .ufl1    (ufl1),
        .tout    (tout),
        .tout_n  (tout_n)
    );

    task automatic chk(input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // one clock cycle: drive, compare against model, advance model
    task automatic cyc(input logic we, input logic [2:0] wa, input logic [7:0] wd,
                       input logic [2:0] ra, input logic ce, input string tag);
        logic ctrl_wr, pre0, pre1, adv0, w0, adv1, w1, sel;
        logic [7:0] exp_rd;
        logic n_run0, n_run1;
        logic [7:0] n_c0, n_c1;
        wr_en = we; wr_addr = wa; wr_data = wd; rd_addr = ra; cnt_en = ce;
        #1;
        ctrl_wr = we && (wa == 3'd0);
        pre0 = we && (wa == 3'd3) && wd[0];
        pre1 = we && (wa == 3'd3) && wd[1];
        adv0 = ce && m_run0 && !pre0;
        w0   = adv0 && (m_c0 == 0);
        adv1 = (m_casc ? w0 : (ce && m_run1)) && !pre1;
        w1   = adv1 && (m_c1 == 0);
        sel  = m_casc ? w1 : (m_sel ? w0 : w1);
        case (ra)
            3'd0: exp_rd = {1'b0, m_ten, m_sel, m_casc, m_os1, m_os0, m_run1, m_run0};
            3'd1: exp_rd = m_rl0;
            3'd2: exp_rd = m_rl1;
            3'd3: exp_rd = m_c0;
            3'd4: exp_rd = m_c1;
            default: exp_rd = 8'h00;
        endcase
        chk(tag, "ufl0", {7'b0, ufl0}, {7'b0, w0});
        chk(tag, "ufl1", {7'b0, ufl1}, {7'b0, w1});
        chk(tag, "tout", {7'b0, tout}, {7'b0, (m_ten ? m_ph : 1'b1)});
        chk(tag, "tout_n", {7'b0, tout_n}, {7'b0, (m_ten ? !m_ph : 1'b0)});
        chk(tag, "rd_data", rd_data, exp_rd);
        n_c0 = pre0 ? m_rl0 : (w0 ? m_rl0 : (adv0 ? m_c0 - 8'd1 : m_c0));
        n_c1 = pre1 ? m_rl1 : (w1 ? m_rl1 : (adv1 ? m_c1 - 8'd1 : m_c1));
        if (ctrl_wr) n_run0 = wd[0];
        else if (m_run0 && m_os0 && (m_casc ? w1 : w0)) n_run0 = 1'b0;
        else n_run0 = m_run0;
        if (m_casc || (ctrl_wr && wd[4])) n_run1 = 1'b0;
        else if (ctrl_wr) n_run1 = wd[1];
        else if (m_run1 && m_os1 && w1) n_run1 = 1'b0;
        else n_run1 = m_run1;
        @(posedge clk);
        m_c0 = n_c0; m_c1 = n_c1; m_run0 = n_run0; m_run1 = n_run1;
        m_ph = m_ph ^ sel;
        if (ctrl_wr) begin
            m_os0 = wd[2]; m_os1 = wd[3]; m_casc = wd[4]; m_sel = wd[5]; m_ten = wd[6];
        end
        if (we && wa == 3'd1) m_rl0 = wd;
        if (we && wa == 3'd2) m_rl1 = wd;
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d, input string tag);
        cyc(1'b1, a, d, 3'd0, 1'b0, tag);
    endtask

    task automatic run(input int n, input logic [2:0] ra, input string tag);
        for (int i = 0; i < n; i++) cyc(1'b0, 3'd0, 8'h00, ra, 1'b1, tag);
    endtask

    initial begin
        #100us;
        n_fail++;
        n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state on every read address
        for (int a = 0; a < 5; a++) cyc(1'b0, 3'(a), 8'h00, 3'(a), 1'b0, "R1");
        // R3: auto-reload period with reload 3
        wr(3'd1, 8'd3, "R12");
        wr(3'd3, 8'h01, "R6");
        wr(3'd0, 8'h01, "R2");
        run(12, 3'd3, "R3");
        cyc(1'b0, 3'd0, 8'h00, 3'd0, 1'b1, "R2");
        // R4: stop, hold, resume
        run(2, 3'd3, "R4");
        wr(3'd0, 8'h00, "R2");
        run(4, 3'd3, "R4");
        wr(3'd0, 8'h01, "R4");
        for (int i = 0; i < 10; i++) cyc(1'b0, 3'd0, 8'h00, 3'd3, 1'(i % 3 != 0), "R4");
        // R6: preset while running and while stopped
        wr(3'd1, 8'd5, "R12");
        wr(3'd3, 8'h01, "R6");
        run(3, 3'd3, "R6");
        wr(3'd0, 8'h00, "R6");
        wr(3'd3, 8'h01, "R6");
        cyc(1'b0, 3'd0, 8'h00, 3'd3, 1'b1, "R6");
        // R5: single-shot on channel 1
        wr(3'd2, 8'd2, "R12");
        wr(3'd3, 8'h02, "R6");
        wr(3'd0, 8'h0A, "R5");
        run(6, 3'd0, "R5");
        run(2, 3'd4, "R5");
        // R9 / R10: select channel 0, wave enabled
        wr(3'd1, 8'd1, "R12");
        wr(3'd3, 8'h03, "R6");
        wr(3'd0, 8'h63, "R9");
        run(12, 3'd0, "R10");
        wr(3'd0, 8'h43, "R9");
        run(12, 3'd4, "R10");
        // R11: enable off while underflows continue
        wr(3'd0, 8'h03, "R11");
        run(8, 3'd3, "R11");
        // R7: cascade, run1 write ignored
        wr(3'd1, 8'd1, "R12");
        wr(3'd2, 8'd2, "R12");
        wr(3'd3, 8'h03, "R6");
        wr(3'd0, 8'h73, "R7");
        run(14, 3'd4, "R7");
        run(4, 3'd0, "R9");
        // R8: cascade single-shot stops on combined underflow
        wr(3'd3, 8'h03, "R6");
        wr(3'd0, 8'h55, "R8");
        run(10, 3'd0, "R8");
        run(3, 3'd3, "R8");
        // R12: unmapped reads
        for (int a = 5; a < 8; a++) cyc(1'b0, 3'd0, 8'h00, 3'(a), 1'b0, "R12");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule